// File: doc/BRIEF.md
# Lockable Non-Maskable Interrupt Edge Detector

This block watches one asynchronous external pin and raises a non-maskable interrupt request that goes straight to the processor core. No interrupt controller and no mask bit sit in the request path. The pin is first brought into the clock domain by a multi-flop synchroniser. An edge detector then compares the synchronised level with its value one cycle earlier. A qualified edge sets a sticky pending flag, and that flag is the request output itself.

Software picks the active edge with a 2-bit select field and turns detection on with an enable bit, both in a single configuration write. The first write that carries the enable bit and a non-zero select locks the configuration until reset. Detection is live only after the lock, and no later write can change or disable it. The processor removes the request with a write-one-to-clear acknowledge. While the system is in low-power stop mode, a pending request also drives a wake request that restarts the stopped system clock.

The configuration controller has two states. `ST_OPEN` is the reset state: configuration writes are stored and detection is inactive. `ST_ARMED` is the locked state: writes are ignored and detection is live. The transition `lock_write` runs from `ST_OPEN` to `ST_ARMED` on a write with the enable bit set and a non-zero select. In `ST_OPEN` any other write keeps the controller in `ST_OPEN` (transition `store_write`). `ST_ARMED` has only a self-transition, and only reset leaves it.

Top module: `nmi_edge_lock`

## Requirements
- R1: After reset, `nmi_req`, `wake_req`, `locked`, `cfg_sel_rd` and `cfg_en_rd` are all 0.
- R2: The select field is encoded as 00 no edge, 01 rising, 10 falling and 11 both. Once the block is locked, an edge of a selected kind sets the request and an edge of an unselected kind does not.
- R3: A configuration write with `cfg_en`=1 and a non-zero `cfg_sel` sets `locked` on the following cycle, and `locked` then stays at 1 until reset. A write with `cfg_en`=0 or with `cfg_sel`=00 is stored and read back, but it does not lock and does not enable detection.
- R4: While the block is locked, configuration writes are ignored. The readback values do not change, and edge detection keeps its original selection.
- R5: The request is sticky. It stays at 1 after the pin returns to its former level, and it clears only on an acknowledge.
- R6: An acknowledge pulse (`ack`=1 for one cycle) clears `nmi_req` on the next clock edge when no new edge is qualified in that cycle.
- R7: If a qualified edge is detected in the same cycle as an acknowledge, `nmi_req` stays at 1.
- R8: `wake_req` is 1 exactly when the request is pending and `stop_mode` is 1. It is 0 whenever `stop_mode` is 0.
- R9: With the default two synchroniser stages, the request appears at the third rising clock edge after a pin change, and is still 0 after the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_async | input | 1 | External interrupt pin, asynchronous to clk |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Edge select written on a configuration write (00 none, 01 rising, 10 falling, 11 both) |
| cfg_en | input | 1 | Detection enable written on a configuration write |
| ack | input | 1 | Write-one-to-clear acknowledge of the pending request |
| stop_mode | input | 1 | System is in low-power stop mode |
| nmi_req | output | 1 | Non-maskable interrupt request to the core (the pending flag) |
| wake_req | output | 1 | Request to restart the system clock |
| locked | output | 1 | Configuration is locked until reset |
| cfg_sel_rd | output | 2 | Readback of the stored edge select |
| cfg_en_rd | output | 1 | Readback of the stored enable bit |

## Verification
All eight combinations of select and enable are applied, each after a fresh reset. For each combination the pin makes one rising and one falling transition, which shows whether the edge select is decoded correctly and whether an unlocked setup ever detects an edge. A rewrite after the lock, with a different select and the enable cleared, shows whether the lock holds. The falling edge that follows must be ignored while rising edges are still caught. Directed sequences then measure the synchroniser latency cycle by cycle, hold the pin level after an edge to show the flag is sticky, line an acknowledge up with the detection cycle, and switch `stop_mode` on and off around a pending request.

// File: rtl/nmi_pkg.sv
package nmi_pkg;
    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;

    typedef enum logic {
        ST_OPEN  = 1'b0,
        ST_ARMED = 1'b1
    } cfg_state_e;
endpackage

// File: rtl/nmi_sync.sv
module nmi_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], din};
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/nmi_cfg_fsm.sv
module nmi_cfg_fsm
    import nmi_pkg::*;
#(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [SEL_W-1:0] wsel,
    input  logic             wen,
    output logic             armed,
    output logic [SEL_W-1:0] sel_q,
    output logic             en_q
);
    cfg_state_e state_q, state_d;
    logic       store_cfg;

    // State and configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OPEN;
            sel_q   <= '0;
            en_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (store_cfg) begin
                sel_q <= wsel;
                en_q  <= wen;
            end
        end
    end

    // Next state and output decode
    always_comb begin
        state_d   = state_q;
        store_cfg = 1'b0;
        armed     = 1'b0;
        unique case (state_q)
            ST_OPEN: begin
                store_cfg = we;
                if (we && wen && (wsel != '0)) state_d = ST_ARMED; // lock_write
            end
            ST_ARMED: begin
                armed = 1'b1;
            end
            default: state_d = ST_OPEN;
        endcase
    end

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED) |=> (state_q == ST_ARMED)); // R3

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED) |=> ($stable(sel_q) && $stable(en_q))); // R4
endmodule

// File: rtl/nmi_edge_det.sv
module nmi_edge_det #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             level,
    input  logic             armed,
    input  logic [SEL_W-1:0] sel,
    input  logic             ack,
    output logic             pending
);
    logic prev_q;
    logic rise, fall, hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q  <= 1'b0;
            pending <= 1'b0;
        end else begin
            prev_q  <= level;
            pending <= hit | (pending & ~ack);
        end
    end

    always_comb begin
        rise = level & ~prev_q;
        fall = ~level & prev_q;
        hit  = armed & ((sel[0] & rise) | (sel[1] & fall));
    end

    AST_HIT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> pending); // R7

    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !ack) |=> pending); // R5

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !hit) |=> !pending); // R6

    AST_NO_DETECT_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !pending) |=> !pending); // R3
endmodule

// File: rtl/nmi_edge_lock.sv
module nmi_edge_lock #(
    parameter int SYNC_STAGES = 2,
    parameter int SEL_W       = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_async,
    input  logic             cfg_we,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic             cfg_en,
    input  logic             ack,
    input  logic             stop_mode,
    output logic             nmi_req,
    output logic             wake_req,
    output logic             locked,
    output logic [SEL_W-1:0] cfg_sel_rd,
    output logic             cfg_en_rd
);
    logic pin_sync;

    nmi_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pin_async),
        .dout (pin_sync)
    );

    nmi_cfg_fsm #(.SEL_W(SEL_W)) u_cfg (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (cfg_we),
        .wsel (cfg_sel),
        .wen  (cfg_en),
        .armed(locked),
        .sel_q(cfg_sel_rd),
        .en_q (cfg_en_rd)
    );

    nmi_edge_det #(.SEL_W(SEL_W)) u_det (
        .clk    (clk),
        .rst_n  (rst_n),
        .level  (pin_sync),
        .armed  (locked),
        .sel    (cfg_sel_rd),
        .ack    (ack),
        .pending(nmi_req)
    );

    assign wake_req = nmi_req & stop_mode;

    AST_WAKE_NEEDS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        !stop_mode |-> !wake_req); // R8

    AST_WAKE_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_mode && nmi_req) |-> wake_req); // R8
endmodule

// File: tb/nmi_edge_lock_tb_top.sv
module nmi_edge_lock_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin_async = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_sel = 2'b00;
    logic       cfg_en = 1'b0;
    logic       ack = 1'b0;
    logic       stop_mode = 1'b0;
    logic       nmi_req, wake_req, locked, cfg_en_rd;
    logic [1:0] cfg_sel_rd;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    nmi_edge_lock dut_i (
        .clk(clk), .rst_n(rst_n), .pin_async(pin_async),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_en(cfg_en),
        .ack(ack), .stop_mode(stop_mode),
        .nmi_req(nmi_req), .wake_req(wake_req), .locked(locked),
        .cfg_sel_rd(cfg_sel_rd), .cfg_en_rd(cfg_en_rd)
    );

    // {sel[1:0], en, expect_rise_detected, expect_fall_detected}
    localparam logic [4:0] VEC [0:7] = '{
        5'b00_0_0_0, 5'b01_0_0_0, 5'b10_0_0_0, 5'b11_0_0_0,
        5'b00_1_0_0, 5'b01_1_1_0, 5'b10_1_0_1, 5'b11_1_1_1
    };

    task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; pin_async = 1'b0; cfg_we = 1'b0; ack = 1'b0; stop_mode = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic write_cfg(input logic [1:0] s, input logic e);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = s; cfg_en = e;
        @(negedge clk);
        cfg_we = 1'b0; cfg_sel = 2'b00; cfg_en = 1'b0;
    endtask

    task automatic drive_pin(input logic v);
        @(negedge clk);
        pin_async = v;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_ack();
        @(negedge clk);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    initial begin
        #3000000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        do_reset();
        @(negedge clk);
        chk("R1 nmi_req", {1'b0, nmi_req}, 2'd0);
        chk("R1 wake_req", {1'b0, wake_req}, 2'd0);
        chk("R1 locked", {1'b0, locked}, 2'd0);
        chk("R1 sel_rd", cfg_sel_rd, 2'd0);
        chk("R1 en_rd", {1'b0, cfg_en_rd}, 2'd0);

        // R2 / R3: vector table over every select and enable combination
        for (int i = 0; i < 8; i++) begin
            do_reset();
            write_cfg(VEC[i][4:3], VEC[i][2]);
            chk("R3 locked after write", {1'b0, locked}, {1'b0, VEC[i][1] | VEC[i][0]});
            chk("R3 sel readback", cfg_sel_rd, VEC[i][4:3]);
            drive_pin(1'b1);
            chk("R2 rising edge", {1'b0, nmi_req}, {1'b0, VEC[i][1]});
            pulse_ack();
            drive_pin(1'b0);
            chk("R2 falling edge", {1'b0, nmi_req}, {1'b0, VEC[i][0]});
            pulse_ack();
        end

        // R4: writes while locked are ignored
        do_reset();
        write_cfg(2'b01, 1'b1);
        write_cfg(2'b10, 1'b0);
        chk("R4 sel unchanged", cfg_sel_rd, 2'b01);
        chk("R4 en unchanged", {1'b0, cfg_en_rd}, 2'd1);
        chk("R4 still locked", {1'b0, locked}, 2'd1);
        drive_pin(1'b1);
        chk("R4 rising still detected", {1'b0, nmi_req}, 2'd1);
        pulse_ack();
        drive_pin(1'b0);
        chk("R4 falling ignored", {1'b0, nmi_req}, 2'd0);

        // R9 latency, R5 stickiness, R6 acknowledge
        do_reset();
        write_cfg(2'b01, 1'b1);
        @(negedge clk);
        pin_async = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        chk("R9 not yet after two edges", {1'b0, nmi_req}, 2'd0);
        @(posedge clk);
        @(negedge clk);
        chk("R9 set at third edge", {1'b0, nmi_req}, 2'd1);
        pin_async = 1'b0;
        repeat (6) @(negedge clk);
        chk("R5 sticky after pin returns", {1'b0, nmi_req}, 2'd1);
        pulse_ack();
        chk("R6 ack clears", {1'b0, nmi_req}, 2'd0);

        // R7: edge in the same cycle as the acknowledge
        drive_pin(1'b1);
        chk("R7 pending before", {1'b0, nmi_req}, 2'd1);
        pulse_ack();
        drive_pin(1'b0);
        @(negedge clk);
        pin_async = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        ack = 1'b1;
        @(posedge clk);
        @(negedge clk);
        ack = 1'b0;
        chk("R7 edge beats ack", {1'b0, nmi_req}, 2'd1);

        // R8: wake request only in stop mode
        chk("R8 no wake outside stop", {1'b0, wake_req}, 2'd0);
        stop_mode = 1'b1;
        @(negedge clk);
        chk("R8 wake in stop", {1'b0, wake_req}, 2'd1);
        pulse_ack();
        chk("R8 wake drops with ack", {1'b0, wake_req}, 2'd0);
        stop_mode = 1'b0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule